// File: doc/BRIEF.md
# Bus-matching dual-clock FIFO

This block is a first-in first-out buffer whose write side and read side run on separate, unrelated clocks. Each side is either 9 or 18 bits wide. The two widths are chosen independently, so the buffer can split 18-bit words into 9-bit halves, join 9-bit halves into 18-bit words, or pass words through unchanged. A byte-order select fixes which 9-bit half of an 18-bit word is stored first or delivered first. Storage is counted in 9-bit units in a register array of `2**ADDR_W` units.

The read side has two timing styles. In the standard style a word reaches the output register only on a read request, and the flags report empty and full. In the fall-through style the oldest word is presented at the output as soon as it is available, and the flags report output-ready and input-ready. A half-full flag in the write domain shows how much is stored. A master reset latches the width, byte-order and timing selects and empties the buffer. A partial reset empties the buffer and keeps the latched selects. While output enable is low, the data output is forced to zero.

Top module: `busmatch_fifo`

## Requirements
- R1: At a master reset, `iw_sel` and `ow_sel` are latched as the write width and read width (0 = 9 bits on bits [8:0], 1 = 18 bits). All four combinations work, and changing the pins after reset has no effect.
- R2: At a rising `wclk` edge with `wen` high and the buffer not full, one input word is stored. With the buffer full, `wen` is ignored and nothing is stored.
- R3: With `big_sel` latched as 1, bits [17:9] of an 18-bit word form the earlier 9-bit unit. With 0, bits [8:0] form the earlier unit. This holds for both splitting and joining. Output bits [17:9] are 0 when the read width is 9.
- R4: In standard timing (`fwft_sel` latched as 0), `rd_flag` is 1 while fewer units are stored than one read word holds. `q_o` changes only at a `rclk` edge where `ren` is high and `rd_flag` is 0, and it then carries the oldest word.
- R5: In fall-through timing, `rd_flag` is 1 exactly while `q_o` holds a valid word. The oldest word appears without any read request. `ren` high at a `rclk` edge while `rd_flag` is 1 consumes that word.
- R6: `wr_flag` means full in standard timing: it is 1 while fewer free units remain than one write word holds. In fall-through timing it means input-ready and is the inverse of that condition.
- R7: `half_flag` is 1 while the units counted in the write domain are at least half of `2**ADDR_W`.
- R8: A master reset or a partial reset empties the buffer (std: `rd_flag`=1, `wr_flag`=0; fall-through: `rd_flag`=0, `wr_flag`=1; `half_flag`=0; `q_o`=0). A partial reset keeps the latched selects.
- R9: While `oe` is 0, `q_o` is all zeros. Raising `oe` again shows the held word.
- R10: Words leave in the order they were written, with no loss or duplication, for every width, byte-order and timing combination and unrelated clock periods.
- R11: With no reads in standard timing, the buffer accepts exactly `2**ADDR_W` units: that many words at write width 9, half as many at width 18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| mrst | input | 1 | Master reset, active high, held across edges of both clocks; latches selects |
| prst | input | 1 | Partial reset, active high, held across edges of both clocks; keeps selects |
| iw_sel | input | 1 | Write width select, 1 = 18 bits |
| ow_sel | input | 1 | Read width select, 1 = 18 bits |
| fwft_sel | input | 1 | Timing select, 1 = fall-through |
| big_sel | input | 1 | Byte-order select, 1 = upper half first |
| wen | input | 1 | Write request |
| din | input | 18 | Write data |
| ren | input | 1 | Read request |
| oe | input | 1 | Output enable |
| q_o | output | 18 | Read data |
| rd_flag | output | 1 | Empty (standard) or output-ready (fall-through) |
| wr_flag | output | 1 | Full (standard) or input-ready (fall-through) |
| half_flag | output | 1 | Half-full status, write domain |

## Verification
The bench covers every combination of the four selects. It compares each word that leaves against a queue of 9-bit units built from the words that went in. A mistake in half ordering shows up as swapped halves in 18-to-9 or 9-to-18 traffic. A pointer that advances by two in Gray code without the paired encoding sends corrupted counts across the clock boundary, and the result is lost or repeated words. The fill tests compare the number of accepted units with the capacity and check the full and half flags at every step: an off-by-one in the free-space test shows up as one word too many or too few. After each master reset the select pins are inverted, and the transfer runs after a partial reset, so a reset that lost the latched selects would deliver data in the wrong width or order.

// File: rtl/bmf_pkg.sv
package bmf_pkg;

    localparam int UNIT_W = 9;
    localparam int WORD_W = 2 * UNIT_W;

    typedef logic [UNIT_W-1:0] unit_t;
    typedef logic [WORD_W-1:0] word_t;

    // selects latched at master reset
    typedef struct packed {
        logic in_wide;
        logic out_wide;
        logic fwft;
        logic big_end;
    } cfg_t;

    // unit that is stored / delivered first
    function automatic unit_t lead_unit(input word_t w, input logic big);
        return big ? w[WORD_W-1:UNIT_W] : w[UNIT_W-1:0];
    endfunction

    function automatic unit_t trail_unit(input word_t w, input logic big);
        return big ? w[UNIT_W-1:0] : w[WORD_W-1:UNIT_W];
    endfunction

    function automatic word_t join_units(input unit_t first, input unit_t second,
                                         input logic big);
        return big ? {first, second} : {second, first};
    endfunction

endpackage

// File: rtl/bmf_ptr_cdc.sv
module bmf_ptr_cdc #(
    parameter int PW = 6
) (
    input  logic          src_clk,
    input  logic          src_rst,
    input  logic          src_wide,
    input  logic [PW-1:0] src_ptr,
    input  logic          dst_clk,
    input  logic          dst_rst,
    input  logic          dst_wide,
    output logic [PW-1:0] dst_ptr
);

    // A wide pointer always moves by two with bit 0 at zero, so only the
    // upper bits are Gray coded and every step flips a single bit.
    function automatic logic [PW-1:0] encode(input logic [PW-1:0] b, input logic wide);
        logic [PW-1:0] h;
        h = wide ? (b >> 1) : b;
        h = h ^ (h >> 1);
        return wide ? {h[PW-2:0], 1'b0} : h;
    endfunction

    function automatic logic [PW-1:0] decode(input logic [PW-1:0] g, input logic wide);
        logic [PW-1:0] h;
        logic [PW-1:0] b;
        h = wide ? {1'b0, g[PW-1:1]} : g;
        b[PW-1] = h[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ h[i];
        end
        return wide ? {b[PW-2:0], 1'b0} : b;
    endfunction

    logic [PW-1:0] gray_q;
    logic [PW-1:0] sync1_q, sync2_q;
    logic          live_q;

    always_ff @(posedge src_clk) begin
        if (src_rst) begin
            gray_q <= '0;
            live_q <= 1'b0;
        end else begin
            gray_q <= encode(src_ptr, src_wide);
            live_q <= 1'b1;
        end
    end

    always_ff @(posedge dst_clk) begin
        if (dst_rst) begin
            sync1_q <= '0;
            sync2_q <= '0;
        end else begin
            sync1_q <= gray_q;
            sync2_q <= sync1_q;
        end
    end

    assign dst_ptr = decode(sync2_q, dst_wide);

    // R10: the crossing code never changes by more than one bit per source cycle
    a_r10_gray_single_step: assert property (@(posedge src_clk) disable iff (src_rst || !live_q)
        $countones(gray_q ^ $past(gray_q)) <= 1);

endmodule

// File: rtl/bmf_store.sv
module bmf_store
    import bmf_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              wclk,
    input  logic              we,
    input  logic              w_wide,
    input  logic              w_big,
    input  logic [ADDR_W-1:0] waddr,
    input  word_t             din,
    input  logic [ADDR_W-1:0] raddr,
    input  logic              r_wide,
    input  logic              r_big,
    output word_t             dout
);

    localparam int DEPTH = 1 << ADDR_W;

    unit_t mem [DEPTH];

    logic [ADDR_W-1:0] waddr_nx, raddr_nx;
    assign waddr_nx = waddr + ADDR_W'(1);
    assign raddr_nx = raddr + ADDR_W'(1);

    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= w_wide ? lead_unit(din, w_big) : din[UNIT_W-1:0];
            if (w_wide) begin
                mem[waddr_nx] <= trail_unit(din, w_big);
            end
        end
    end

    unit_t u_first, u_second;
    assign u_first  = mem[raddr];
    assign u_second = mem[raddr_nx];

    assign dout = r_wide ? join_units(u_first, u_second, r_big)
                         : {{UNIT_W{1'b0}}, u_first};

endmodule

// File: rtl/bmf_wr.sv
module bmf_wr
    import bmf_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              mrst,
    input  logic              prst,
    input  cfg_t              cfg_pins,
    input  logic              wen,
    input  logic [ADDR_W:0]   rptr_s,
    output cfg_t              cfg,
    output logic [ADDR_W:0]   wptr,
    output logic              push,
    output logic              full,
    output logic              half
);

    localparam int PW    = ADDR_W + 1;
    localparam int UNITS = 1 << ADDR_W;

    logic          rst;
    logic [PW-1:0] step, used, free;

    assign rst  = mrst | prst;
    assign step = cfg.in_wide ? PW'(2) : PW'(1);
    assign used = wptr - rptr_s;
    assign free = PW'(UNITS) - used;
    assign full = free < step;
    assign half = used >= PW'(UNITS / 2);
    assign push = wen & ~full;

    always_ff @(posedge clk) begin
        if (mrst) begin
            cfg <= cfg_pins;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
        end else if (push) begin
            wptr <= wptr + step;
        end
    end

    a_r11_used_bound: assert property (@(posedge clk) disable iff (rst)
        used <= PW'(UNITS));

    a_r1_wide_ptr_even: assert property (@(posedge clk) disable iff (rst)
        cfg.in_wide |-> !wptr[0]);

    a_r7_full_implies_half: assert property (@(posedge clk) disable iff (rst)
        full |-> half);

    a_r2_full_blocks_write: assert property (@(posedge clk) disable iff (rst)
        (wen && full) |=> $stable(wptr));

    a_r8_prst_keeps_cfg: assert property (@(posedge clk) disable iff (mrst)
        prst |=> $stable(cfg));

endmodule

// File: rtl/bmf_rd.sv
module bmf_rd
    import bmf_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              mrst,
    input  logic              prst,
    input  cfg_t              cfg_pins,
    input  logic              ren,
    input  logic [ADDR_W:0]   wptr_s,
    input  word_t             mem_word,
    output cfg_t              cfg,
    output logic [ADDR_W:0]   rptr,
    output word_t             q,
    output logic              rd_flag
);

    localparam int PW    = ADDR_W + 1;
    localparam int UNITS = 1 << ADDR_W;

    logic          rst;
    logic [PW-1:0] step, avail;
    logic          short_w, take, valid;

    assign rst     = mrst | prst;
    assign step    = cfg.out_wide ? PW'(2) : PW'(1);
    assign avail   = wptr_s - rptr;
    assign short_w = avail < step;
    assign take    = cfg.fwft ? (!short_w && (!valid || ren)) : (ren && !short_w);
    assign rd_flag = cfg.fwft ? valid : short_w;

    always_ff @(posedge clk) begin
        if (mrst) begin
            cfg <= cfg_pins;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rptr  <= '0;
            q     <= '0;
            valid <= 1'b0;
        end else begin
            if (take) begin
                rptr <= rptr + step;
                q    <= mem_word;
            end
            if (!cfg.fwft) begin
                valid <= 1'b0;
            end else if (take) begin
                valid <= 1'b1;
            end else if (ren) begin
                valid <= 1'b0;
            end
        end
    end

    a_r10_avail_bound: assert property (@(posedge clk) disable iff (rst)
        avail <= PW'(UNITS));

    a_r4_hold_without_read: assert property (@(posedge clk) disable iff (rst)
        (!cfg.fwft && !ren) |=> $stable(q));

    a_r5_ready_holds: assert property (@(posedge clk) disable iff (rst)
        (cfg.fwft && valid && !ren) |=> (valid && $stable(q)));

    a_r3_narrow_upper_zero: assert property (@(posedge clk) disable iff (rst)
        !cfg.out_wide |-> (q[WORD_W-1:UNIT_W] == '0));

endmodule

// File: rtl/busmatch_fifo.sv
module busmatch_fifo
    import bmf_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic        wclk,
    input  logic        rclk,
    input  logic        mrst,
    input  logic        prst,
    input  logic        iw_sel,
    input  logic        ow_sel,
    input  logic        fwft_sel,
    input  logic        big_sel,
    input  logic        wen,
    input  logic [17:0] din,
    input  logic        ren,
    input  logic        oe,
    output logic [17:0] q_o,
    output logic        rd_flag,
    output logic        wr_flag,
    output logic        half_flag
);

    localparam int PW = ADDR_W + 1;

    cfg_t          pins, cfg_w, cfg_r;
    logic [PW-1:0] wptr, rptr, wptr_s, rptr_s;
    logic          push, full, half;
    word_t         mem_word, q_r;
    logic          wrst, rrst;

    assign pins = '{in_wide: iw_sel, out_wide: ow_sel, fwft: fwft_sel, big_end: big_sel};
    assign wrst = mrst | prst;
    assign rrst = mrst | prst;

    bmf_wr #(.ADDR_W(ADDR_W)) u_wr (
        .clk      (wclk),
        .mrst     (mrst),
        .prst     (prst),
        .cfg_pins (pins),
        .wen      (wen),
        .rptr_s   (rptr_s),
        .cfg      (cfg_w),
        .wptr     (wptr),
        .push     (push),
        .full     (full),
        .half     (half)
    );

    bmf_rd #(.ADDR_W(ADDR_W)) u_rd (
        .clk      (rclk),
        .mrst     (mrst),
        .prst     (prst),
        .cfg_pins (pins),
        .ren      (ren),
        .wptr_s   (wptr_s),
        .mem_word (mem_word),
        .cfg      (cfg_r),
        .rptr     (rptr),
        .q        (q_r),
        .rd_flag  (rd_flag)
    );

    bmf_store #(.ADDR_W(ADDR_W)) u_store (
        .wclk   (wclk),
        .we     (push),
        .w_wide (cfg_w.in_wide),
        .w_big  (cfg_w.big_end),
        .waddr  (wptr[ADDR_W-1:0]),
        .din    (din),
        .raddr  (rptr[ADDR_W-1:0]),
        .r_wide (cfg_r.out_wide),
        .r_big  (cfg_r.big_end),
        .dout   (mem_word)
    );

    bmf_ptr_cdc #(.PW(PW)) u_w2r (
        .src_clk  (wclk),
        .src_rst  (wrst),
        .src_wide (cfg_w.in_wide),
        .src_ptr  (wptr),
        .dst_clk  (rclk),
        .dst_rst  (rrst),
        .dst_wide (cfg_r.in_wide),
        .dst_ptr  (wptr_s)
    );

    bmf_ptr_cdc #(.PW(PW)) u_r2w (
        .src_clk  (rclk),
        .src_rst  (rrst),
        .src_wide (cfg_r.out_wide),
        .src_ptr  (rptr),
        .dst_clk  (wclk),
        .dst_rst  (wrst),
        .dst_wide (cfg_w.out_wide),
        .dst_ptr  (rptr_s)
    );

    assign q_o       = oe ? q_r : '0;
    assign wr_flag   = cfg_w.fwft ? ~full : full;
    assign half_flag = half;

endmodule

// File: tb/test_busmatch_fifo.sv
module test_busmatch_fifo;

    localparam int CLK_PERIOD = 10;
    localparam int RCLK_PERIOD = CLK_PERIOD * 7 / 5;
    localparam int ADDR_W = 5;
    localparam int UNITS = 1 << ADDR_W;
    localparam int NWORDS = 40;

    logic        wclk = 1'b0, rclk = 1'b0;
    logic        mrst = 1'b0, prst = 1'b0;
    logic        iw_sel = 1'b0, ow_sel = 1'b0, fwft_sel = 1'b0, big_sel = 1'b0;
    logic        wen = 1'b0, ren = 1'b0, oe = 1'b1;
    logic [17:0] din = '0;
    logic [17:0] q_o;
    logic        rd_flag, wr_flag, half_flag;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    bit c_fw, c_iw, c_ow, c_big;
    logic [8:0] ref_q[$];

    always #(CLK_PERIOD / 2) wclk = ~wclk;
    always #(RCLK_PERIOD / 2) rclk = ~rclk;

    busmatch_fifo #(.ADDR_W(ADDR_W)) i_busmatch_fifo (
        .wclk(wclk), .rclk(rclk), .mrst(mrst), .prst(prst),
        .iw_sel(iw_sel), .ow_sel(ow_sel), .fwft_sel(fwft_sel), .big_sel(big_sel),
        .wen(wen), .din(din), .ren(ren), .oe(oe),
        .q_o(q_o), .rd_flag(rd_flag), .wr_flag(wr_flag), .half_flag(half_flag)
    );

    task automatic check(input bit ok, input string req, input logic [17:0] act,
                         input logic [17:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h (cfg fw=%0d iw=%0d ow=%0d big=%0d)",
                     req, act, exp, c_fw, c_iw, c_ow, c_big);
        end
    endtask

    function automatic logic [17:0] pat(input int k);
        return {9'(k * 23 + 101), 9'(k * 41 + 7)};
    endfunction

    task automatic push_word(input logic [17:0] w);
        if (c_iw) begin
            ref_q.push_back(c_big ? w[17:9] : w[8:0]);
            ref_q.push_back(c_big ? w[8:0] : w[17:9]);
        end else begin
            ref_q.push_back(w[8:0]);
        end
    endtask

    function automatic logic [17:0] peek_word();
        if (c_ow) return c_big ? {ref_q[0], ref_q[1]} : {ref_q[1], ref_q[0]};
        return {9'b0, ref_q[0]};
    endfunction

    task automatic pop_word();
        void'(ref_q.pop_front());
        if (c_ow) void'(ref_q.pop_front());
    endtask

    task automatic pulse_reset(input bit master);
        @(negedge wclk);
        if (master) mrst = 1'b1; else prst = 1'b1;
        repeat (6) @(negedge wclk);
        mrst = 1'b0;
        prst = 1'b0;
        repeat (4) @(negedge wclk);
        @(negedge rclk);
    endtask

    // R8: flags and output after either reset
    task automatic check_reset_state(input string tag);
        check(rd_flag == (c_fw ? 1'b0 : 1'b1), {tag, " rd_flag"}, 18'(rd_flag), 18'(!c_fw));
        check(wr_flag == (c_fw ? 1'b1 : 1'b0), {tag, " wr_flag"}, 18'(wr_flag), 18'(c_fw));
        check(half_flag == 1'b0, {tag, " half_flag"}, 18'(half_flag), 18'(0));
        check(q_o == '0, {tag, " q_o"}, q_o, '0);
    endtask

    // R11, R6, R7: fill with no reads
    task automatic fill_test();
        int units = 0;
        int iwn = c_iw ? 2 : 1;
        int own = c_ow ? 2 : 1;
        int expect_units;
        for (int k = 0; k < 120; k++) begin
            @(negedge wclk);
            if (!c_fw) begin
                check(half_flag == (units >= UNITS / 2), "R7 half boundary",
                      18'(half_flag), 18'(units >= UNITS / 2));
                check(wr_flag == (units + iwn > UNITS), "R6 full boundary",
                      18'(wr_flag), 18'(units + iwn > UNITS));
            end
            wen = 1'b1;
            din = pat(units / iwn);
            if (c_fw ? wr_flag : !wr_flag) begin
                push_word(din);
                units += iwn;
            end
        end
        @(negedge wclk);
        wen = 1'b0;
        repeat (8) @(negedge wclk);
        expect_units = c_fw ? UNITS + ((own >= iwn) ? own : 0) : UNITS;
        check(units == expect_units, "R11 capacity", 18'(units), 18'(expect_units));
        check(wr_flag == (c_fw ? 1'b0 : 1'b1), "R6 full at capacity", 18'(wr_flag), 18'(!c_fw));
        check(half_flag == 1'b1, "R7 half at capacity", 18'(half_flag), 18'(1));
        @(negedge rclk);
        if (c_fw) begin
            check(rd_flag == 1'b1, "R5 ready without read", 18'(rd_flag), 18'(1));
            check(q_o == peek_word(), "R5 first word falls through", q_o, peek_word());
            oe = 1'b0;
            #1;
            check(q_o == '0, "R9 output idle", q_o, '0);
            oe = 1'b1;
            #1;
            check(q_o == peek_word(), "R9 output restored", q_o, peek_word());
        end else begin
            check(rd_flag == 1'b0, "R4 not empty", 18'(rd_flag), 18'(0));
            check(q_o == '0, "R4 no data before read", q_o, '0);
        end
    endtask

    task automatic run_writer();
        int k = 0;
        int cyc = 0;
        while (k < NWORDS) begin
            @(negedge wclk);
            wen = ((cyc % 5) != 3);
            din = pat(k + 300);
            if (wen && (c_fw ? wr_flag : !wr_flag)) begin
                push_word(din);
                k++;
            end
            cyc++;
        end
        @(negedge wclk);
        wen = 1'b0;
    endtask

    // R10, R3, R4, R5: read and compare against the unit queue
    task automatic run_reader();
        int own = c_ow ? 2 : 1;
        int target = ((NWORDS * (c_iw ? 2 : 1)) / own) * own;
        int got = 0;
        int cyc = 0;
        bit pend = 0;
        logic [17:0] exp_w = '0;
        if (!c_fw) begin
            while (got < target || pend) begin
                @(negedge rclk);
                if (pend) begin
                    check(q_o == exp_w, "R10 R3 R4 std read data", q_o, exp_w);
                    pend = 0;
                end
                if (got < target) begin
                    ren = ((cyc % 3) != 1);
                    if (ren && !rd_flag) begin
                        exp_w = peek_word();
                        pop_word();
                        pend = 1;
                        got += own;
                    end
                end else begin
                    ren = 1'b0;
                end
                cyc++;
            end
        end else begin
            while (got < target) begin
                @(negedge rclk);
                ren = ((cyc % 3) != 1);
                if (rd_flag) begin
                    check(q_o == peek_word(), "R10 R3 R5 fwft read data", q_o, peek_word());
                    if (ren) begin
                        pop_word();
                        got += own;
                    end
                end
                cyc++;
            end
        end
        @(negedge rclk);
        ren = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge wclk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 16; c++) begin
            c_fw  = c[3];
            c_iw  = c[2];
            c_ow  = c[1];
            c_big = c[0];
            fwft_sel = c_fw;
            iw_sel   = c_iw;
            ow_sel   = c_ow;
            big_sel  = c_big;
            ref_q.delete();
            pulse_reset(1'b1);
            // R1: pins changed after master reset must not matter
            fwft_sel = !c_fw;
            iw_sel   = !c_iw;
            ow_sel   = !c_ow;
            big_sel  = !c_big;
            check_reset_state("R8 R1 after master reset");
            fill_test();
            pulse_reset(1'b0);
            ref_q.delete();
            check_reset_state("R8 after partial reset");
            fork
                run_writer();
                run_reader();
            join
            repeat (12) @(negedge wclk);
            @(negedge rclk);
            check(ref_q.size() == 0, "R10 nothing lost", 18'(ref_q.size()), 18'(0));
            check(rd_flag == (c_fw ? 1'b0 : 1'b1), "R4 R5 drained flag",
                  18'(rd_flag), 18'(!c_fw));
            check(half_flag == 1'b0, "R7 drained half", 18'(half_flag), 18'(0));
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule